// File: doc/BRIEF.md
# Two-Argument Arctangent Front End (Special Cases and Octant Reduction)

This block is the entry stage of a single-precision atan2(y, x) unit. It sorts each operand into one of four classes: NaN, infinity, zero of either sign, or finite non-zero (subnormals count as finite). When the operand pair falls into any IEEE special case, the block resolves it completely and emits the final 32-bit result marked as a bypass.

When both operands are finite and non-zero, the block emits a reduction command for a downstream arctangent core. The command names a numerator and a denominator whose quotient has magnitude at most 1. It also carries a code for the multiple of π/2 to add afterwards and a flag that tells whether the core result must be negated before that add. Because the core result is bounded by π/4 in magnitude, the final add cannot cancel significance.

The input side is a one-cycle valid strobe. The output appears one clock later with its own valid strobe. No back-pressure exists.

Top module: `atan2r_front`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and it is low after reset and after any cycle without `in_valid`.
- R2: A NaN in x (exponent all ones, fraction non-zero) takes precedence over everything else, including a NaN in y. It is returned as the result with fraction bit 22 forced to 1.
- R3: When x is not a NaN and y is a NaN, y is returned with fraction bit 22 forced to 1.
- R4: When x = +∞: if y is ±∞ the result is π/4 carrying the sign of y; otherwise the result is a zero carrying the sign of y.
- R5: When x = −∞: if y is ±∞ the result is 3π/4 carrying the sign of y; otherwise the result is π carrying the sign of y.
- R6: When x is finite or zero and y is ±∞, the result is π/2 carrying the sign of y.
- R7: For zeros, the cases apply in this order. If x is ±0 and y is finite non-zero, the result is π/2 with the sign of y. If y is ±0 and the sign bit of x is 0, the result is a zero with the sign of y. If y is ±0 and the sign bit of x is 1, the result is π with the sign of y.
- R8: For finite non-zero operands, bits [30:0] of each operand are compared as unsigned integers. When |y| ≤ |x|, swap = 0, numerator = y and denominator = x. Otherwise swap = 1, numerator = x and denominator = y.
- R9: Offset codes are 0 = none, 1 = +π/2, 2 = −π/2, 3 = +π and 4 = −π. With swap = 0, the code is 0 for x > 0, 3 for x < 0 with y > 0, and 4 for x < 0 with y < 0, and negate = 0. With swap = 1, the code is 1 for y > 0 and 2 for y < 0, and negate = 1.
- R10: The constants are exact bit patterns: π = 0x40490FDB, π/2 = 0x3FC90FDB, π/4 = 0x3F490FDB and 3π/4 = 0x4016CBE4. Negative versions differ only in bit 31.
- R11: `out_bypass` is 1 only for the special cases. While it is 1, swap, offset, negate, numerator and denominator are all zero. While it is 0, `out_result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_x | input | 32 | Operand x (denominator side) |
| in_y | input | 32 | Operand y (numerator side) |
| out_valid | output | 1 | Output fields valid |
| out_bypass | output | 1 | Special case resolved; `out_result` is final |
| out_result | output | 32 | Final result for special cases |
| out_swap | output | 1 | Quotient is x/y instead of y/x |
| out_offset | output | 3 | Code for the π/2 multiple to add |
| out_negate | output | 1 | Negate the core result before the add |
| out_num | output | 32 | Numerator for the core |
| out_den | output | 32 | Denominator for the core |

## Verification
The assertions assume that `in_x` and `in_y` hold known values in every cycle where `in_valid` is high. They also assume that between strobes the outputs are judged only while `out_valid` is high. The stimulus drives operands only on the falling edge, together with a one-cycle strobe, and drops the strobe before the next pair. This keeps every operand stable across the capturing edge. The pattern list covers NaN payloads of both signalling and quiet kinds, every infinity and signed-zero row, equal magnitudes and subnormals, so that each branch of the priority chain is reached with known operands.

// File: rtl/atan2r_pkg.sv
package atan2r_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int MAG_W  = WORD_W - 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [MAG_W-1:0]  mag_t;

  typedef enum logic [1:0] {CLS_ZERO, CLS_FIN, CLS_INF, CLS_NAN} cls_e;
  typedef enum logic [2:0] {
    OFS_NONE  = 3'd0,
    OFS_PHALF = 3'd1,
    OFS_NHALF = 3'd2,
    OFS_PPI   = 3'd3,
    OFS_NPI   = 3'd4
  } ofs_e;

  // Rounded single-precision constants, positive forms.
  localparam word_t K_PI      = 32'h40490FDB;
  localparam word_t K_HALF_PI = 32'h3FC90FDB;
  localparam word_t K_QTR_PI  = 32'h3F490FDB;
  localparam word_t K_3QTR_PI = 32'h4016CBE4;
  localparam word_t K_ZERO    = '0;

  function automatic logic f_sign(word_t w);
    return w[WORD_W-1];
  endfunction

  function automatic mag_t f_mag(word_t w);
    return w[MAG_W-1:0];
  endfunction

  function automatic cls_e f_classify(word_t w);
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] m;
    e = w[WORD_W-2 -: EXP_W];
    m = w[MAN_W-1:0];
    if (&e)            return (m != '0) ? CLS_NAN : CLS_INF;
    else if (w[MAG_W-1:0] == '0) return CLS_ZERO;
    else               return CLS_FIN;
  endfunction

  function automatic word_t f_quiet(word_t w);
    word_t q;
    q = w;
    q[MAN_W-1] = 1'b1;
    return q;
  endfunction

  function automatic word_t f_with_sign(logic s, word_t k);
    return {s, k[MAG_W-1:0]};
  endfunction
endpackage

// File: rtl/atan2r_classify.sv
module atan2r_classify
  import atan2r_pkg::*;
(
  input  word_t op,
  output cls_e  cls
);
  assign cls = f_classify(op);
endmodule

// File: rtl/atan2r_special.sv
module atan2r_special
  import atan2r_pkg::*;
(
  input  word_t      x_w,
  input  word_t      y_w,
  input  cls_e       x_cls,
  input  cls_e       y_cls,
  output logic       hit,
  output word_t      result,
  output logic [3:0] rule
);
  logic ys;
  logic xs;
  assign ys = f_sign(y_w);
  assign xs = f_sign(x_w);

  // Ordered chain: earlier rows shadow later ones.
  always_comb begin
    hit    = 1'b1;
    result = K_ZERO;
    rule   = 4'd0;
    if (x_cls == CLS_NAN) begin
      result = f_quiet(x_w);                       rule = 4'd1;
    end else if (y_cls == CLS_NAN) begin
      result = f_quiet(y_w);                       rule = 4'd2;
    end else if (x_cls == CLS_INF && !xs) begin
      if (y_cls == CLS_INF) begin
        result = f_with_sign(ys, K_QTR_PI);        rule = 4'd3;
      end else begin
        result = f_with_sign(ys, K_ZERO);          rule = 4'd4;
      end
    end else if (x_cls == CLS_INF) begin
      if (y_cls == CLS_INF) begin
        result = f_with_sign(ys, K_3QTR_PI);       rule = 4'd5;
      end else begin
        result = f_with_sign(ys, K_PI);            rule = 4'd6;
      end
    end else if (y_cls == CLS_INF) begin
      result = f_with_sign(ys, K_HALF_PI);         rule = 4'd7;
    end else if (x_cls == CLS_ZERO && y_cls != CLS_ZERO) begin
      result = f_with_sign(ys, K_HALF_PI);         rule = 4'd8;
    end else if (y_cls == CLS_ZERO && !xs) begin
      result = f_with_sign(ys, K_ZERO);            rule = 4'd9;
    end else if (y_cls == CLS_ZERO) begin
      result = f_with_sign(ys, K_PI);              rule = 4'd10;
    end else begin
      hit    = 1'b0;
    end
  end
endmodule

// File: rtl/atan2r_octant.sv
module atan2r_octant
  import atan2r_pkg::*;
(
  input  word_t x_w,
  input  word_t y_w,
  output logic  swap,
  output ofs_e  ofs,
  output logic  negate,
  output word_t num,
  output word_t den
);
  logic y_le_x;
  assign y_le_x = f_mag(y_w) <= f_mag(x_w);

  always_comb begin
    swap   = !y_le_x;
    negate = !y_le_x;
    num    = y_le_x ? y_w : x_w;
    den    = y_le_x ? x_w : y_w;
    if (y_le_x) begin
      if (!f_sign(x_w))      ofs = OFS_NONE;
      else if (!f_sign(y_w)) ofs = OFS_PPI;
      else                   ofs = OFS_NPI;
    end else begin
      ofs = f_sign(y_w) ? OFS_NHALF : OFS_PHALF;
    end
  end
endmodule

// File: rtl/atan2r_front.sv
module atan2r_front
  import atan2r_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_x,
  input  logic [31:0] in_y,
  output logic        out_valid,
  output logic        out_bypass,
  output logic [31:0] out_result,
  output logic        out_swap,
  output logic [2:0]  out_offset,
  output logic        out_negate,
  output logic [31:0] out_num,
  output logic [31:0] out_den
);
  localparam int NUM_OPS = 2;

  word_t op_w   [NUM_OPS];
  cls_e  op_cls [NUM_OPS];
  assign op_w[0] = in_x;
  assign op_w[1] = in_y;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
    atan2r_classify u_cls (.op(op_w[i]), .cls(op_cls[i]));
  end

  logic       sp_hit;
  word_t      sp_result;
  logic [3:0] sp_rule;

  atan2r_special u_special (
    .x_w(op_w[0]), .y_w(op_w[1]),
    .x_cls(op_cls[0]), .y_cls(op_cls[1]),
    .hit(sp_hit), .result(sp_result), .rule(sp_rule)
  );

  logic  oc_swap;
  ofs_e  oc_ofs;
  logic  oc_negate;
  word_t oc_num;
  word_t oc_den;

  atan2r_octant u_octant (
    .x_w(op_w[0]), .y_w(op_w[1]),
    .swap(oc_swap), .ofs(oc_ofs), .negate(oc_negate),
    .num(oc_num), .den(oc_den)
  );

  // Named events for the assertions.
  logic ev_x_nan;
  logic ev_both_finite;
  assign ev_x_nan       = in_valid && (op_cls[0] == CLS_NAN);
  assign ev_both_finite = in_valid && (op_cls[0] == CLS_FIN) && (op_cls[1] == CLS_FIN);

  logic  vld_q, byp_q, swap_q, neg_q;
  word_t res_q, num_q, den_q;
  ofs_e  ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      byp_q  <= 1'b0;
      res_q  <= '0;
      swap_q <= 1'b0;
      ofs_q  <= OFS_NONE;
      neg_q  <= 1'b0;
      num_q  <= '0;
      den_q  <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        byp_q  <= sp_hit;
        res_q  <= sp_hit ? sp_result : K_ZERO;
        swap_q <= sp_hit ? 1'b0 : oc_swap;
        ofs_q  <= sp_hit ? OFS_NONE : oc_ofs;
        neg_q  <= sp_hit ? 1'b0 : oc_negate;
        num_q  <= sp_hit ? K_ZERO : oc_num;
        den_q  <= sp_hit ? K_ZERO : oc_den;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_bypass = byp_q;
  assign out_result = res_q;
  assign out_swap   = swap_q;
  assign out_offset = ofs_q;
  assign out_negate = neg_q;
  assign out_num    = num_q;
  assign out_den    = den_q;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_NAN_X_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_x_nan |=> out_bypass && (&out_result[30:23]) && out_result[22]
                 && out_result[31] == $past(in_x[31])); // R2
  AST_FINITE_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_both_finite |=> !out_bypass && out_result == 32'h0); // R11
  AST_QUOTIENT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bypass |-> out_num[30:0] <= out_den[30:0]); // R8
  AST_SWAP_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bypass && out_swap |-> (out_offset == 3'd1 || out_offset == 3'd2)); // R9
  AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bypass |-> !out_swap && !out_negate && out_offset == 3'd0); // R11
endmodule

// File: tb/atan2r_front_tb.sv
module atan2r_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_x = '0;
  logic [31:0] in_y = '0;
  logic        out_valid, out_bypass, out_swap, out_negate;
  logic [31:0] out_result, out_num, out_den;
  logic [2:0]  out_offset;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  atan2r_front u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_bypass(out_bypass), .out_result(out_result),
    .out_swap(out_swap), .out_offset(out_offset), .out_negate(out_negate),
    .out_num(out_num), .out_den(out_den)
  );

  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] ONE = 32'h3F800000, NONE = 32'hBF800000;
  localparam logic [31:0] TWO = 32'h40000000, NTWO = 32'hC0000000;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // One scenario: drive on a falling edge, sample on the next falling edge.
  task automatic run_case(string tag, logic [31:0] x, logic [31:0] y,
                          logic e_byp, logic [31:0] e_res,
                          logic e_swap, logic [2:0] e_ofs, logic e_neg);
    @(negedge clk);
    in_x = x; in_y = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "valid after strobe", {31'b0, out_valid}, 32'd1);
    chk("R11", "bypass", {31'b0, out_bypass}, {31'b0, e_byp});
    chk(tag, "result", out_result, e_byp ? e_res : 32'h0);
    chk(e_byp ? "R11" : "R8", "swap", {31'b0, out_swap}, {31'b0, e_swap});
    chk(e_byp ? "R11" : "R9", "offset", {29'b0, out_offset}, {29'b0, e_ofs});
    chk(e_byp ? "R11" : "R9", "negate", {31'b0, out_negate}, {31'b0, e_neg});
    chk(e_byp ? "R11" : "R8", "num", out_num, e_byp ? 32'h0 : (e_swap ? x : y));
    chk(e_byp ? "R11" : "R8", "den", out_den, e_byp ? 32'h0 : (e_swap ? y : x));
    @(negedge clk);
    chk("R1", "valid drops", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "reset valid", {31'b0, out_valid}, 32'd0);
    chk("R11", "reset bypass", {31'b0, out_bypass}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle valid", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_nan();
    run_case("R2", 32'h7F800001, 32'h7FA00000, 1, 32'h7FC00001, 0, 0, 0);
    run_case("R2", 32'hFF800005, ONE,          1, 32'hFFC00005, 0, 0, 0);
    run_case("R2", 32'h7FC00007, PINF,         1, 32'h7FC00007, 0, 0, 0);
    run_case("R3", ONE, 32'h7F800002,          1, 32'h7FC00002, 0, 0, 0);
    run_case("R3", NINF, 32'hFFC00000,         1, 32'hFFC00000, 0, 0, 0);
    run_case("R3", PZ, 32'h7F812345,           1, 32'h7FC12345, 0, 0, 0);
  endtask

  task automatic t_inf();
    run_case("R4 R10", PINF, PINF, 1, 32'h3F490FDB, 0, 0, 0);
    run_case("R4 R10", PINF, NINF, 1, 32'hBF490FDB, 0, 0, 0);
    run_case("R4", PINF, NONE,     1, NZ, 0, 0, 0);
    run_case("R4", PINF, PZ,       1, PZ, 0, 0, 0);
    run_case("R5 R10", NINF, PINF, 1, 32'h4016CBE4, 0, 0, 0);
    run_case("R5 R10", NINF, NINF, 1, 32'hC016CBE4, 0, 0, 0);
    run_case("R5 R10", NINF, ONE,  1, 32'h40490FDB, 0, 0, 0);
    run_case("R5", NINF, NZ,       1, 32'hC0490FDB, 0, 0, 0);
    run_case("R6 R10", ONE, PINF,  1, 32'h3FC90FDB, 0, 0, 0);
    run_case("R6", NZ, NINF,       1, 32'hBFC90FDB, 0, 0, 0);
  endtask

  task automatic t_zero();
    run_case("R7", PZ, TWO,           1, 32'h3FC90FDB, 0, 0, 0);
    run_case("R7", NZ, NTWO,          1, 32'hBFC90FDB, 0, 0, 0);
    run_case("R7", PZ, NZ,            1, NZ, 0, 0, 0);
    run_case("R7", 32'h40400000, PZ,  1, PZ, 0, 0, 0);
    run_case("R7", NZ, PZ,            1, 32'h40490FDB, 0, 0, 0);
    run_case("R7", 32'hC0400000, NZ,  1, 32'hC0490FDB, 0, 0, 0);
  endtask

  task automatic t_octants();
    run_case("R9", TWO,  ONE,  0, 0, 0, 3'd0, 0);
    run_case("R9", TWO,  NONE, 0, 0, 0, 3'd0, 0);
    run_case("R9", NTWO, ONE,  0, 0, 0, 3'd3, 0);
    run_case("R9", NTWO, NONE, 0, 0, 0, 3'd4, 0);
    run_case("R9", ONE,  TWO,  0, 0, 1, 3'd1, 1);
    run_case("R9", NONE, TWO,  0, 0, 1, 3'd1, 1);
    run_case("R9", ONE,  NTWO, 0, 0, 1, 3'd2, 1);
    run_case("R9", NONE, NTWO, 0, 0, 1, 3'd2, 1);
  endtask

  task automatic t_magnitude();
    run_case("R8", NTWO, TWO, 0, 0, 0, 3'd3, 0);
    run_case("R8", 32'h00000002, 32'h00000001, 0, 0, 0, 3'd0, 0);
    run_case("R8", 32'h00000003, 32'h80000005, 0, 0, 1, 3'd2, 1);
    run_case("R8", 32'h3F800001, 32'hBF800000, 0, 0, 0, 3'd0, 0);
  endtask

  initial begin
    t_reset();
    t_nan();
    t_inf();
    t_zero();
    t_octants();
    t_magnitude();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule